// File: doc/BRIEF.md
# Interrupt Event Register with Set and Clear Ports

This block holds the 32-bit interrupt event word of a serial-bus host controller. Hardware strobes from the PHY interface, the cycle timer, the configuration-ROM loader and the DMA contexts set individual event bits. Software changes the word through two write ports. One port sets every bit written as 1. The other port clears every bit written as 1. A read at the set offset returns the raw event word. A read at the clear offset returns the event word filtered by the interrupt mask.

The mask arrives as a plain input vector. Bit 31 of the mask acts as the master enable. The registered interrupt output is high when the master enable is on and at least one event bit is also enabled in the mask. Three events affect other state:
- A bus-reset strobe clears the self-ID-complete bit.
- A cycle-too-long strobe clears the cycle-master enable flag.
- While the unrecoverable-error bit is set, event strobes from contexts flagged as dead cannot set their bits.

Top module: `irq_event_reg`

## Requirements
- R1: A write to offset 0x80 sets every non-reserved event bit whose data bit is 1. Bits written as 0 keep their value. A write to any offset other than 0x80 or 0x84 has no effect.
- R2: A write to offset 0x84 clears every event bit whose data bit is 1. Bits written as 0 keep their value.
- R3: Bits 31, 29, 28, 27 and 18 always read as 0, and no write or strobe can set them.
- R4: A read (rd_en_i high) returns data on rdata_o one cycle later. At offset 0x80 the data is the raw event word. At offset 0x84 it is the event word ANDed with mask_i. At any other offset it is 0. In a cycle after no read, rdata_o is 0.
- R5: Each strobe sets its bit one cycle later: ROM done sets bit 30, PHY register byte sets bit 26, cycle too long sets bit 25, unrecoverable error sets bit 24, cycle inconsistent sets bit 23, cycle lost sets bit 22, 64-second rollover sets bit 21, cycle start sets bit 20, PHY status request sets bit 19, bus reset sets bit 17, self-ID complete sets bit 16. Context event i sets bit i (i in 0..15).
- R6: When a hardware strobe and a software clear hit the same bit in the same cycle, the bit ends up set.
- R7: In the cycle that the bus-reset strobe sets bit 17, bit 16 is cleared, even if the self-ID strobe is high in that same cycle.
- R8: cycle_master_o becomes 1 one cycle after cm_set_i. It becomes 0 one cycle after the cycle-too-long strobe. If both are high in the same cycle, the clear wins.
- R9: While event bit 24 is set, a context event strobe i is ignored if ctx_dead_i[i] is high. Contexts that are not dead still set their bits.
- R10: irq_o is registered. It equals mask_i[31] AND the OR of (event word AND mask_i), taken from the previous cycle's values.
- R11: A synchronous active-high reset clears the event word, rdata_o, irq_o and cycle_master_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| mask_i | input | 32 | Interrupt mask; bit 31 is the master enable |
| ctx_evt_i | input | 16 | Per-context event strobes (bits 15:0) |
| ctx_dead_i | input | 16 | Per-context failed flags |
| ev_rom_done_i | input | 1 | Configuration-ROM read finished |
| ev_phy_reg_i | input | 1 | PHY register byte arrived |
| ev_cyc_long_i | input | 1 | Cycle too long |
| ev_unrec_i | input | 1 | Unrecoverable error |
| ev_cyc_incons_i | input | 1 | Received cycle time mismatch |
| ev_cyc_lost_i | input | 1 | Cycle start missing |
| ev_cyc64_i | input | 1 | 64-second counter rollover |
| ev_cyc_synch_i | input | 1 | New isochronous cycle |
| ev_phy_irq_i | input | 1 | PHY status-transfer interrupt request |
| ev_bus_reset_i | input | 1 | Bus reset entered |
| ev_selfid_i | input | 1 | Self-ID stream received |
| cm_set_i | input | 1 | Enable the cycle-master flag |
| cycle_master_o | output | 1 | Cycle-master enable flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A wrong event bit shows on rdata_o at the first read of either offset: one cycle after that read for a single-bit fault. It also shows on irq_o one cycle after the faulty bit is enabled in the mask. A missed side effect shows in two ways. A self-ID bit that survives a bus reset shows on the next read. A cycle-master flag that is not cleared shows on cycle_master_o one cycle after the cycle-too-long strobe. Faults in context gating and in set-versus-clear priority only show when the bench builds the exact cycle collision and then reads the word back.

// File: rtl/irq_ev_pkg.sv
package irq_ev_pkg;
  localparam int EW        = 32;
  localparam int NCTX_MAX  = 16;
  localparam int OFF_SET   = 'h80;
  localparam int OFF_CLR   = 'h84;
  localparam int B_ROM     = 30;
  localparam int B_PHYREG  = 26;
  localparam int B_CLONG   = 25;
  localparam int B_UNREC   = 24;
  localparam int B_INCONS  = 23;
  localparam int B_LOST    = 22;
  localparam int B_C64     = 21;
  localparam int B_SYNCH   = 20;
  localparam int B_PHYIRQ  = 19;
  localparam int B_BRST    = 17;
  localparam int B_SELFID  = 16;
  localparam int MEN_BIT   = 31;
  localparam logic [EW-1:0] RSVD_MASK  = 32'hB804_0000;
  localparam logic [EW-1:0] VALID_MASK = ~RSVD_MASK;
endpackage

// File: rtl/irq_hw_gather.sv
module irq_hw_gather
  import irq_ev_pkg::*;
#(
  parameter int NCTX = 16
) (
  input  logic            unrec_q,
  input  logic [NCTX-1:0] ctx_evt_i,
  input  logic [NCTX-1:0] ctx_dead_i,
  input  logic            ev_rom_done_i,
  input  logic            ev_phy_reg_i,
  input  logic            ev_cyc_long_i,
  input  logic            ev_unrec_i,
  input  logic            ev_cyc_incons_i,
  input  logic            ev_cyc_lost_i,
  input  logic            ev_cyc64_i,
  input  logic            ev_cyc_synch_i,
  input  logic            ev_phy_irq_i,
  input  logic            ev_bus_reset_i,
  input  logic            ev_selfid_i,
  output logic [EW-1:0]   hw_set,
  output logic            brst_hit
);
  logic [NCTX_MAX-1:0] ctx_set;

  for (genvar i = 0; i < NCTX_MAX; i++) begin : g_ctx
    if (i < NCTX) begin : g_used
      assign ctx_set[i] = ctx_evt_i[i] & ~(unrec_q & ctx_dead_i[i]);
    end else begin : g_unused
      assign ctx_set[i] = 1'b0;
    end
  end

  always_comb begin
    hw_set                    = '0;
    hw_set[NCTX_MAX-1:0]      = ctx_set;
    hw_set[B_ROM]             = ev_rom_done_i;
    hw_set[B_PHYREG]          = ev_phy_reg_i;
    hw_set[B_CLONG]           = ev_cyc_long_i;
    hw_set[B_UNREC]           = ev_unrec_i;
    hw_set[B_INCONS]          = ev_cyc_incons_i;
    hw_set[B_LOST]            = ev_cyc_lost_i;
    hw_set[B_C64]             = ev_cyc64_i;
    hw_set[B_SYNCH]           = ev_cyc_synch_i;
    hw_set[B_PHYIRQ]          = ev_phy_irq_i;
    hw_set[B_BRST]            = ev_bus_reset_i;
    hw_set[B_SELFID]          = ev_selfid_i;
  end

  assign brst_hit = ev_bus_reset_i;
endmodule

// File: rtl/irq_event_bits.sv
module irq_event_bits
  import irq_ev_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [EW-1:0] sw_set,
  input  logic [EW-1:0] sw_clr,
  input  logic [EW-1:0] hw_set,
  input  logic          brst_hit,
  output logic [EW-1:0] ev_q
);
  logic [EW-1:0] ev_nxt;

  always_comb begin
    ev_nxt = ((ev_q | sw_set) & ~sw_clr) | hw_set;
    if (brst_hit) ev_nxt[B_SELFID] = 1'b0;
    ev_nxt = ev_nxt & VALID_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) ev_q <= '0;
    else     ev_q <= ev_nxt;
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_ev_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [EW-1:0] ev_q,
  input  logic [EW-1:0] mask_i,
  output logic [EW-1:0] rdata_o
);
  localparam logic [AW-1:0] A_SET = AW'(OFF_SET);
  localparam logic [AW-1:0] A_CLR = AW'(OFF_CLR);

  logic [EW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (rd_en_i) begin
      if (addr_i == A_SET)      rd_mux = ev_q;
      else if (addr_i == A_CLR) rd_mux = ev_q & mask_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irq_out.sv
module irq_out
  import irq_ev_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [EW-1:0] ev_q,
  input  logic [EW-1:0] mask_i,
  output logic          irq_o
);
  logic any_hit;

  assign any_hit = |(ev_q & mask_i);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= mask_i[MEN_BIT] & any_hit;
  end
endmodule

// File: rtl/irq_event_reg.sv
module irq_event_reg
  import irq_ev_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NCTX = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  input  logic [31:0]     mask_i,
  input  logic [NCTX-1:0] ctx_evt_i,
  input  logic [NCTX-1:0] ctx_dead_i,
  input  logic            ev_rom_done_i,
  input  logic            ev_phy_reg_i,
  input  logic            ev_cyc_long_i,
  input  logic            ev_unrec_i,
  input  logic            ev_cyc_incons_i,
  input  logic            ev_cyc_lost_i,
  input  logic            ev_cyc64_i,
  input  logic            ev_cyc_synch_i,
  input  logic            ev_phy_irq_i,
  input  logic            ev_bus_reset_i,
  input  logic            ev_selfid_i,
  input  logic            cm_set_i,
  output logic            cycle_master_o,
  output logic            irq_o
);
  localparam logic [AW-1:0] A_SET = AW'(OFF_SET);
  localparam logic [AW-1:0] A_CLR = AW'(OFF_CLR);

  logic [EW-1:0] ev_q;
  logic [EW-1:0] hw_set;
  logic [EW-1:0] sw_set;
  logic [EW-1:0] sw_clr;
  logic          brst_hit;

  assign sw_set = (wr_en_i && addr_i == A_SET) ? wdata_i : '0;
  assign sw_clr = (wr_en_i && addr_i == A_CLR) ? wdata_i : '0;

  irq_hw_gather #(.NCTX(NCTX)) u_gather (
    .unrec_q         (ev_q[B_UNREC]),
    .ctx_evt_i       (ctx_evt_i),
    .ctx_dead_i      (ctx_dead_i),
    .ev_rom_done_i   (ev_rom_done_i),
    .ev_phy_reg_i    (ev_phy_reg_i),
    .ev_cyc_long_i   (ev_cyc_long_i),
    .ev_unrec_i      (ev_unrec_i),
    .ev_cyc_incons_i (ev_cyc_incons_i),
    .ev_cyc_lost_i   (ev_cyc_lost_i),
    .ev_cyc64_i      (ev_cyc64_i),
    .ev_cyc_synch_i  (ev_cyc_synch_i),
    .ev_phy_irq_i    (ev_phy_irq_i),
    .ev_bus_reset_i  (ev_bus_reset_i),
    .ev_selfid_i     (ev_selfid_i),
    .hw_set          (hw_set),
    .brst_hit        (brst_hit)
  );

  irq_event_bits u_bits (
    .clk      (clk),
    .rst      (rst),
    .sw_set   (sw_set),
    .sw_clr   (sw_clr),
    .hw_set   (hw_set),
    .brst_hit (brst_hit),
    .ev_q     (ev_q)
  );

  irq_read_port #(.AW(AW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .ev_q    (ev_q),
    .mask_i  (mask_i),
    .rdata_o (rdata_o)
  );

  irq_out u_irq (
    .clk    (clk),
    .rst    (rst),
    .ev_q   (ev_q),
    .mask_i (mask_i),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                cycle_master_o <= 1'b0;
    else if (ev_cyc_long_i) cycle_master_o <= 1'b0;
    else if (cm_set_i)      cycle_master_o <= 1'b1;
  end
endmodule

// File: rtl/irq_event_reg_chk.sv
module irq_event_reg_chk
  import irq_ev_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NCTX = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [AW-1:0]   addr_i,
  input logic [31:0]     wdata_i,
  input logic [31:0]     rdata_o,
  input logic [31:0]     mask_i,
  input logic [NCTX-1:0] ctx_evt_i,
  input logic [NCTX-1:0] ctx_dead_i,
  input logic            ev_cyc_long_i,
  input logic            ev_phy_irq_i,
  input logic            ev_bus_reset_i,
  input logic            cycle_master_o,
  input logic            irq_o,
  input logic [31:0]     ev_q
);
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rdata_o & RSVD_MASK) == 32'h0);

  p_no_read_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> rdata_o == 32'h0);

  p_hw_beats_clear_r6: assert property (@(posedge clk) disable iff (rst)
    ev_phy_irq_i |=> ev_q[B_PHYIRQ]);

  p_selfid_drop_r7: assert property (@(posedge clk) disable iff (rst)
    ev_bus_reset_i |=> !ev_q[B_SELFID]);

  p_cm_clear_r8: assert property (@(posedge clk) disable iff (rst)
    ev_cyc_long_i |=> !cycle_master_o);

  p_ctx_block_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_q[B_UNREC] && ctx_dead_i[0] && ctx_evt_i[0] && !ev_q[0] &&
     !(wr_en_i && addr_i == AW'(OFF_SET) && wdata_i[0])) |=> !ev_q[0]);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(mask_i[MEN_BIT]));
endmodule

bind irq_event_reg irq_event_reg_chk #(.AW(AW), .NCTX(NCTX)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .wr_en_i        (wr_en_i),
  .rd_en_i        (rd_en_i),
  .addr_i         (addr_i),
  .wdata_i        (wdata_i),
  .rdata_o        (rdata_o),
  .mask_i         (mask_i),
  .ctx_evt_i      (ctx_evt_i),
  .ctx_dead_i     (ctx_dead_i),
  .ev_cyc_long_i  (ev_cyc_long_i),
  .ev_phy_irq_i   (ev_phy_irq_i),
  .ev_bus_reset_i (ev_bus_reset_i),
  .cycle_master_o (cycle_master_o),
  .irq_o          (irq_o),
  .ev_q           (ev_q)
);

// File: tb/irq_event_reg_bench.sv
module irq_event_reg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o, mask_i = '0;
  logic [15:0] ctx_evt_i = '0, ctx_dead_i = '0;
  logic ev_rom_done_i = 0, ev_phy_reg_i = 0, ev_cyc_long_i = 0, ev_unrec_i = 0;
  logic ev_cyc_incons_i = 0, ev_cyc_lost_i = 0, ev_cyc64_i = 0, ev_cyc_synch_i = 0;
  logic ev_phy_irq_i = 0, ev_bus_reset_i = 0, ev_selfid_i = 0, cm_set_i = 0;
  logic cycle_master_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  irq_event_reg u_irq_event_reg (.*);

  // vector: {set word, clear word, expected raw read}
  localparam logic [95:0] VEC [6] = '{
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h47FB_FFFF},
    {32'h0000_FFFF, 32'h0000_00F0, 32'h0000_FF0F},
    {32'hFFFF_0000, 32'h4000_0000, 32'h07FB_0000},
    {32'h0005_0003, 32'h0001_0001, 32'h0000_0002},
    {32'hA5A5_A5A5, 32'h0000_0000, 32'h05A1_A5A5},
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en_i = 1; addr_i = a;
    @(negedge clk); d = rdata_o; rd_en_i = 0;
  endtask

  task automatic clear_all();
    wr(8'h84, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    check("R11 irq", {31'h0, irq_o}, 32'h0);
    check("R11 cycle_master", {31'h0, cycle_master_o}, 32'h0);
    check("R11 rdata", rdata_o, 32'h0);
    rd(8'h80, rv); check("R11 event word", rv, 32'h0);

    // R1 R2 R3 vector table
    for (int i = 0; i < 6; i++) begin
      clear_all();
      wr(8'h80, VEC[i][95:64]);
      wr(8'h84, VEC[i][63:32]);
      rd(8'h80, rv);
      check("R1 R2 R3 vector", rv, VEC[i][31:0]);
    end

    // R3 reserved-only write
    clear_all(); wr(8'h80, 32'hB804_0000); rd(8'h80, rv);
    check("R3 reserved write", rv, 32'h0);
    // R1 unknown offset write ignored
    wr(8'h88, 32'hFFFF_FFFF); rd(8'h80, rv);
    check("R1 other offset write", rv, 32'h0);

    // R4 reads
    wr(8'h80, 32'h0003_0005);
    mask_i = 32'h8001_0004;
    rd(8'h84, rv); check("R4 masked read", rv, 32'h0001_0004);
    rd(8'h80, rv); check("R4 raw read", rv, 32'h0003_0005);
    rd(8'h88, rv); check("R4 other offset read", rv, 32'h0);
    @(negedge clk); check("R4 idle rdata", rdata_o, 32'h0);

    // R10 interrupt output
    check("R10 irq on", {31'h0, irq_o}, 32'h1);
    mask_i = 32'h0001_0004;
    @(negedge clk); check("R10 master off", {31'h0, irq_o}, 32'h0);
    mask_i = 32'h8000_0008;
    @(negedge clk); check("R10 no match", {31'h0, irq_o}, 32'h0);
    mask_i = 32'h8000_0001;
    @(negedge clk); check("R10 match bit0", {31'h0, irq_o}, 32'h1);
    mask_i = '0;

    // R5 all strobes except bus reset
    clear_all();
    @(negedge clk);
    ev_rom_done_i = 1; ev_phy_reg_i = 1; ev_cyc_long_i = 1; ev_unrec_i = 1;
    ev_cyc_incons_i = 1; ev_cyc_lost_i = 1; ev_cyc64_i = 1; ev_cyc_synch_i = 1;
    ev_phy_irq_i = 1; ev_selfid_i = 1; ctx_evt_i = 16'h0001;
    @(negedge clk);
    ev_rom_done_i = 0; ev_phy_reg_i = 0; ev_cyc_long_i = 0; ev_unrec_i = 0;
    ev_cyc_incons_i = 0; ev_cyc_lost_i = 0; ev_cyc64_i = 0; ev_cyc_synch_i = 0;
    ev_phy_irq_i = 0; ev_selfid_i = 0; ctx_evt_i = '0;
    rd(8'h80, rv); check("R5 strobes", rv, 32'h47F9_0001);

    // R7 bus reset drops self-ID
    clear_all();
    @(negedge clk); ev_selfid_i = 1;
    @(negedge clk); ev_selfid_i = 0; ev_bus_reset_i = 1;
    @(negedge clk); ev_bus_reset_i = 0;
    rd(8'h80, rv); check("R7 bus reset after selfid", rv, 32'h0002_0000);
    clear_all();
    @(negedge clk); ev_selfid_i = 1; ev_bus_reset_i = 1;
    @(negedge clk); ev_selfid_i = 0; ev_bus_reset_i = 0;
    rd(8'h80, rv); check("R7 same-cycle", rv, 32'h0002_0000);

    // R8 cycle master
    @(negedge clk); cm_set_i = 1;
    @(negedge clk); cm_set_i = 0;
    check("R8 set", {31'h0, cycle_master_o}, 32'h1);
    ev_cyc_long_i = 1;
    @(negedge clk); ev_cyc_long_i = 0;
    check("R8 cleared", {31'h0, cycle_master_o}, 32'h0);
    cm_set_i = 1; ev_cyc_long_i = 1;
    @(negedge clk); cm_set_i = 0; ev_cyc_long_i = 0;
    check("R8 clear wins", {31'h0, cycle_master_o}, 32'h0);

    // R9 dead contexts blocked
    clear_all();
    @(negedge clk); ev_unrec_i = 1;
    @(negedge clk); ev_unrec_i = 0; ctx_dead_i = 16'h0003; ctx_evt_i = 16'h000F;
    @(negedge clk); ctx_evt_i = '0;
    rd(8'h80, rv); check("R9 blocked", rv, 32'h0100_000C);
    wr(8'h84, 32'h0100_0000);
    @(negedge clk); ctx_evt_i = 16'h0003;
    @(negedge clk); ctx_evt_i = '0; ctx_dead_i = '0;
    rd(8'h80, rv); check("R9 unblocked", rv, 32'h0000_000F);

    // R6 hardware set beats software clear
    clear_all();
    @(negedge clk); wr_en_i = 1; addr_i = 8'h84; wdata_i = 32'hFFFF_FFFF; ev_phy_irq_i = 1;
    @(negedge clk); wr_en_i = 0; wdata_i = '0; ev_phy_irq_i = 0;
    rd(8'h80, rv); check("R6 set wins", rv, 32'h0008_0000);

    // R11 reset mid-run
    wr(8'h80, 32'h0000_00FF);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(8'h80, rv); check("R11 reset clears", rv, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule